// File: doc/BRIEF.md
# Frame Statistics Counter Bank

This block counts Ethernet frame events for the host. A receive path raises a one-cycle pulse whenever an incoming frame is dropped because no host receive buffer is free. Each such pulse adds one to a 16-bit missed-frame count. When that count passes its maximum it wraps to zero and a sticky overflow flag is set. A parameterised set of general management counters, 32 bits wide by default, counts other single-cycle frame events from the receive and transmit paths. These counters stop at all ones instead of wrapping.

Software reaches the block through a single-cycle register port: an address, a write strobe with write data, a read strobe, and registered read data. A control word holds two bits. The freeze bit stops every counter from moving on frame events. The reset-on-read bit makes a read of a management counter clear that counter. The missed-frame count and its flag clear on every read, whether or not these bits are set. A read clears a counter even while freeze holds it. An event that arrives in the same cycle as a clearing read is kept, so the counter ends at one.

Top module: `frame_stat_bank`

## Requirements
- R1: Each cycle with `ev_miss` high and freeze clear adds one to the 16-bit missed-frame count.
- R2: A read of word address 1 returns the missed-frame count in bits 15:0 and the overflow flag in bit 16, with zeros above. The read then clears both the count and the flag. This also happens while freeze is set.
- R3: An increment from 0xFFFF sets the count to 0 and sets the overflow flag. The flag stays set through later events until a read of address 1 clears it.
- R4: The control word is at address 0. Bit 3 is freeze and bit 2 is reset-on-read. Writes to every other bit are ignored, and those bits read as zero.
- R5: While freeze is 1, no frame event changes any counter.
- R6: With reset-on-read set, reading management counter i clears it, and this also applies while freeze is set. With reset-on-read clear, reading the counter leaves its value unchanged.
- R7: When an event and a clearing read of the same counter fall in the same cycle, the read returns the old value and the counter ends at 1 (freeze clear).
- R8: Management counters are MGMT_W bits wide (32 by default). They count `ev_mgmt[i]` pulses and hold at all ones instead of wrapping.
- R9: Word address 2+i reads management counter i. Addresses that map to nothing read as zero. Writes to any address other than 0 have no effect.
- R10: `reg_rdata` is updated on the clock edge that samples `reg_rd`. It holds its value in cycles without a read.
- R11: A synchronous active-low reset clears every counter, the overflow flag, the control bits and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_miss | input | 1 | Pulse: received frame dropped because no host buffer was free |
| ev_mgmt | input | NUM_MGMT | Pulse per management counter event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
Every result appears one cycle after its stimulus. An event pulse or a control write sampled at edge N shows in the counter or control state after edge N. A read strobe sampled at edge N loads `reg_rdata` at that same edge and applies its clearing side effect there too. The bench drives each input on a falling edge and removes it on the next falling edge, so exactly one rising edge sees it. It compares `reg_rdata` on the falling edge that follows the read. The effect of an event can therefore be seen at the earliest by a read issued in the next cycle, and the same-cycle cases are driven as a single combined strobe.

// File: rtl/fsb_pkg.sv
// Shared constants and types for the frame statistics counter bank.
// Assumes word addressing on the register port and a 32-bit data bus.
package fsb_pkg;
    localparam int DATA_W    = 32;
    localparam int CTL_ADDR  = 0;
    localparam int MISS_ADDR = 1;
    localparam int MGMT_BASE = 2;
    localparam int FRZ_BIT   = 3;
    localparam int RR_BIT    = 2;

    typedef struct packed {
        logic frz;
        logic rr;
    } ctl_t;
endpackage

// File: rtl/fsb_ctl_reg.sv
// Control word: holds the freeze and reset-on-read bits.
// Assumes a write strobe that lasts one cycle. Every other data bit is discarded.
module fsb_ctl_reg
    import fsb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl
);
    logic hit;
    logic unused_wbits;

    // Decode a write aimed at the control word.
    assign hit = wr && (addr == ADDR_W'(CTL_ADDR));

    // Reserved write bits are dropped on purpose.
    assign unused_wbits = ^{wdata[DATA_W-1:FRZ_BIT+1], wdata[RR_BIT-1:0]};

    // Load the two live control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (hit) begin
            ctl.frz <= wdata[FRZ_BIT];
            ctl.rr  <= wdata[RR_BIT];
        end
    end
endmodule

// File: rtl/fsb_missed_cnt.sv
// Missed-frame counter: wraps at its maximum and sets a sticky overflow flag.
// Assumes clr is one cycle wide. A clear is applied before the increment of
// the same cycle, so no event is lost.
module fsb_missed_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         frz,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_base, cnt_d;
    logic         ovf_base, ovf_d;

    // Next state: clear first, then the increment with wrap detection.
    always_comb begin
        cnt_base = clr ? '0 : cnt;
        ovf_base = clr ? 1'b0 : ovf;
        cnt_d    = cnt_base;
        ovf_d    = ovf_base;
        if (inc && !frz) begin
            if (cnt_base == CNT_MAX) begin
                cnt_d = '0;
                ovf_d = 1'b1;
            end else begin
                cnt_d = cnt_base + W'(1);
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            cnt <= cnt_d;
            ovf <= ovf_d;
        end
    end
endmodule

// File: rtl/fsb_sat_cnt.sv
// Management counter that stops at all ones instead of wrapping.
// Assumes clr already folds in the reset-on-read bit. Clear is applied
// before the increment of the same cycle.
module fsb_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         frz,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] base, nxt;

    // Next state: clear, then an increment that stops at the top.
    always_comb begin
        base = clr ? '0 : cnt;
        nxt  = base;
        if (inc && !frz && (base != CNT_MAX)) begin
            nxt = base + W'(1);
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= nxt;
        end
    end
endmodule

// File: rtl/fsb_rd_mux.sv
// Read-data path: selects the addressed word and registers it on a read.
// Assumes MISS_W + 1 <= 32 and MGMT_W <= 32. Unmapped addresses return zero.
module fsb_rd_mux
    import fsb_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int MISS_W   = 16,
    parameter int MGMT_W   = 32,
    parameter int NUM_MGMT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd,
    input  logic [ADDR_W-1:0]          addr,
    input  ctl_t                       ctl,
    input  logic [MISS_W-1:0]          miss_cnt,
    input  logic                       miss_ovf,
    input  logic [NUM_MGMT*MGMT_W-1:0] mgmt_flat,
    output logic [DATA_W-1:0]          rdata
);
    logic [DATA_W-1:0] word;

    // Address decode into one data word.
    always_comb begin
        word = '0;
        if (addr == ADDR_W'(CTL_ADDR)) begin
            word[FRZ_BIT] = ctl.frz;
            word[RR_BIT]  = ctl.rr;
        end else if (addr == ADDR_W'(MISS_ADDR)) begin
            word = DATA_W'({miss_ovf, miss_cnt});
        end else begin
            for (int i = 0; i < NUM_MGMT; i++) begin
                if (addr == ADDR_W'(MGMT_BASE + i)) begin
                    word = DATA_W'(mgmt_flat[i*MGMT_W +: MGMT_W]);
                end
            end
        end
    end

    // Capture the word on a read and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= word;
        end
    end
endmodule

// File: rtl/frame_stat_bank.sv
// Frame statistics counter bank: a missed-frame counter with a wrap flag,
// NUM_MGMT saturating management counters, and a control word with freeze
// and reset-on-read. Assumes every event input is a clean one-cycle pulse
// in the clk domain.
module frame_stat_bank
    import fsb_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int MISS_W   = 16,
    parameter int MGMT_W   = 32,
    parameter int NUM_MGMT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_miss,
    input  logic [NUM_MGMT-1:0] ev_mgmt,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata
);
    localparam int FLAT_W = NUM_MGMT * MGMT_W;

    ctl_t              ctl;
    logic              ctl_frz;
    logic              ctl_rr;
    logic              miss_rd;
    logic [MISS_W-1:0] miss_cnt;
    logic              miss_ovf;
    logic [FLAT_W-1:0] mgmt_flat;

    // Control word.
    fsb_ctl_reg #(.ADDR_W(ADDR_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctl   (ctl)
    );

    assign ctl_frz = ctl.frz;
    assign ctl_rr  = ctl.rr;

    // A read of the missed-frame word always clears it.
    assign miss_rd = reg_rd && (reg_addr == ADDR_W'(MISS_ADDR));

    fsb_missed_cnt #(.W(MISS_W)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ev_miss),
        .frz   (ctl_frz),
        .clr   (miss_rd),
        .cnt   (miss_cnt),
        .ovf   (miss_ovf)
    );

    // One saturating counter per management event line.
    for (genvar i = 0; i < NUM_MGMT; i++) begin : g_mgmt
        logic rd_hit;
        assign rd_hit = reg_rd && (reg_addr == ADDR_W'(MGMT_BASE + i));

        fsb_sat_cnt #(.W(MGMT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev_mgmt[i]),
            .frz   (ctl_frz),
            .clr   (rd_hit && ctl_rr),
            .cnt   (mgmt_flat[i*MGMT_W +: MGMT_W])
        );
    end

    // Registered read-data path.
    fsb_rd_mux #(
        .ADDR_W   (ADDR_W),
        .MISS_W   (MISS_W),
        .MGMT_W   (MGMT_W),
        .NUM_MGMT (NUM_MGMT)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .ctl       (ctl),
        .miss_cnt  (miss_cnt),
        .miss_ovf  (miss_ovf),
        .mgmt_flat (mgmt_flat),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/fsb_checker.sv
// Temporal checks for frame_stat_bank, attached through bind below.
module fsb_checker
    import fsb_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int MISS_W   = 16,
    parameter int MGMT_W   = 32,
    parameter int NUM_MGMT = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ev_miss,
    input logic [NUM_MGMT-1:0]        ev_mgmt,
    input logic                       reg_rd,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [31:0]                reg_rdata,
    input logic                       ctl_frz,
    input logic                       ctl_rr,
    input logic [MISS_W-1:0]          miss_cnt,
    input logic                       miss_ovf,
    input logic [NUM_MGMT*MGMT_W-1:0] mgmt_flat
);
    logic miss_rd;
    assign miss_rd = reg_rd && (reg_addr == ADDR_W'(MISS_ADDR));

    // R1
    miss_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_miss && !ctl_frz && !miss_rd && (miss_cnt != '1))
        |=> (miss_cnt == $past(miss_cnt) + MISS_W'(1)));

    // R2
    miss_rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_rd |=> (reg_rdata == 32'({$past(miss_ovf), $past(miss_cnt)})));

    // R2
    miss_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_rd && !ev_miss) |=> (miss_cnt == '0) && !miss_ovf);

    // R3
    miss_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_miss && !ctl_frz && !miss_rd && (miss_cnt == '1))
        |=> (miss_cnt == '0) && miss_ovf);

    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_ovf && !miss_rd) |=> miss_ovf);

    // R4
    ctl_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == ADDR_W'(CTL_ADDR)))
        |=> (reg_rdata[31:4] == '0) && (reg_rdata[1:0] == '0));

    // R5
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_frz && !reg_rd) |=> $stable(miss_cnt) && $stable(mgmt_flat));

    // R7
    miss_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_rd && ev_miss && !ctl_frz) |=> (miss_cnt == MISS_W'(1)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    for (genvar g = 0; g < NUM_MGMT; g++) begin : g_chk
        logic clr_g;
        assign clr_g = reg_rd && ctl_rr && (reg_addr == ADDR_W'(MGMT_BASE + g));

        // R8
        mgmt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((mgmt_flat[g*MGMT_W +: MGMT_W] == '1) && !clr_g)
            |=> (mgmt_flat[g*MGMT_W +: MGMT_W] == '1));

        // R8
        mgmt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_mgmt[g] && !ctl_frz && !clr_g && (mgmt_flat[g*MGMT_W +: MGMT_W] != '1))
            |=> (mgmt_flat[g*MGMT_W +: MGMT_W] == $past(mgmt_flat[g*MGMT_W +: MGMT_W]) + MGMT_W'(1)));

        // R6
        mgmt_rr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_g && !ev_mgmt[g]) |=> (mgmt_flat[g*MGMT_W +: MGMT_W] == '0));
    end
endmodule

bind frame_stat_bank fsb_checker #(
    .ADDR_W   (ADDR_W),
    .MISS_W   (MISS_W),
    .MGMT_W   (MGMT_W),
    .NUM_MGMT (NUM_MGMT)
) u_fsb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_miss   (ev_miss),
    .ev_mgmt   (ev_mgmt),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .ctl_frz   (ctl_frz),
    .ctl_rr    (ctl_rr),
    .miss_cnt  (miss_cnt),
    .miss_ovf  (miss_ovf),
    .mgmt_flat (mgmt_flat)
);

// File: tb/frame_stat_bank_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module frame_stat_bank_bench;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_EV = 2'd1;
    localparam logic [1:0] OP_RD = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] arg;   // write data, or event mask {mgmt[3:0], miss}
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 4'd0,  32'h0,        32'h0,        4'd11}, // R11 control after reset
        '{OP_RD, 4'd1,  32'h0,        32'h0,        4'd11}, // R11
        '{OP_RD, 4'd2,  32'h0,        32'h0,        4'd11}, // R11
        '{OP_WR, 4'd0,  32'hFFFF_FFFF,32'h0,        4'd4},
        '{OP_RD, 4'd0,  32'h0,        32'h0000_000C,4'd4},  // R4 reserved bits
        '{OP_WR, 4'd0,  32'h0,        32'h0,        4'd4},
        '{OP_RD, 4'd0,  32'h0,        32'h0,        4'd4},
        '{OP_EV, 4'd0,  32'h03,       32'h0,        4'd1},
        '{OP_EV, 4'd0,  32'h03,       32'h0,        4'd1},
        '{OP_EV, 4'd0,  32'h03,       32'h0,        4'd1},
        '{OP_RD, 4'd1,  32'h0,        32'h3,        4'd1},  // R1
        '{OP_RD, 4'd1,  32'h0,        32'h0,        4'd2},  // R2 clear on read
        '{OP_RD, 4'd2,  32'h0,        32'h3,        4'd9},  // R9 mgmt0
        '{OP_RD, 4'd2,  32'h0,        32'h3,        4'd6},  // R6 no clear, rr=0
        '{OP_WR, 4'd1,  32'h0000_FFFF,32'h0,        4'd9},
        '{OP_EV, 4'd0,  32'h01,       32'h0,        4'd9},
        '{OP_RD, 4'd1,  32'h0,        32'h1,        4'd9},  // R9 write ignored
        '{OP_WR, 4'd0,  32'h4,        32'h0,        4'd6},
        '{OP_RD, 4'd2,  32'h0,        32'h3,        4'd6},
        '{OP_RD, 4'd2,  32'h0,        32'h0,        4'd6},  // R6 cleared
        '{OP_EV, 4'd0,  32'h04,       32'h0,        4'd5},
        '{OP_EV, 4'd0,  32'h04,       32'h0,        4'd5},
        '{OP_WR, 4'd0,  32'hC,        32'h0,        4'd5},
        '{OP_EV, 4'd0,  32'h1F,       32'h0,        4'd5},
        '{OP_EV, 4'd0,  32'h1F,       32'h0,        4'd5},
        '{OP_RD, 4'd1,  32'h0,        32'h0,        4'd5},  // R5 miss frozen
        '{OP_RD, 4'd3,  32'h0,        32'h2,        4'd5},  // R5 mgmt1 frozen
        '{OP_RD, 4'd3,  32'h0,        32'h0,        4'd6},  // R6 clear under freeze
        '{OP_RD, 4'd4,  32'h0,        32'h0,        4'd5},
        '{OP_WR, 4'd0,  32'h0,        32'h0,        4'd4},
        '{OP_EV, 4'd0,  32'h10,       32'h0,        4'd9},
        '{OP_RD, 4'd5,  32'h0,        32'h1,        4'd9},  // R9 mgmt3
        '{OP_RD, 4'd15, 32'h0,        32'h0,        4'd9},  // R9 unmapped
        '{OP_RD, 4'd5,  32'h0,        32'h1,        4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_miss = 1'b0;
    logic [3:0]  ev_mgmt = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    logic [3:0]  s_ev = '0;
    logic        s_rd = 1'b0;
    logic [3:0]  s_addr = '0;
    logic [31:0] s_rdata;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    frame_stat_bank u_frame_stat_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_miss   (ev_miss),
        .ev_mgmt   (ev_mgmt),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // Narrow instance so saturation is reachable in a short run.
    frame_stat_bank #(.MGMT_W(8)) u_frame_stat_bank_sat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_miss   (1'b0),
        .ev_mgmt   (s_ev),
        .reg_wr    (1'b0),
        .reg_rd    (s_rd),
        .reg_addr  (s_addr),
        .reg_wdata (32'h0),
        .reg_rdata (s_rdata)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [4:0] m);
        ev_miss = m[0]; ev_mgmt = m[4:1];
        @(negedge clk);
        ev_miss = 1'b0; ev_mgmt = '0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(reg_rdata, exp, tag);
    endtask

    // Event and read sampled on the same edge.
    task automatic combo_chk(input logic [4:0] m, input logic [3:0] a,
                             input logic [31:0] exp, input string tag);
        ev_miss = m[0]; ev_mgmt = m[4:1]; reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        ev_miss = 1'b0; ev_mgmt = '0; reg_rd = 1'b0;
        check(reg_rdata, exp, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R10: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(reg_rdata, 32'h0, "R11 rdata after reset");

        for (int k = 0; k < NV; k++) begin
            case (VEC[k].op)
                OP_WR: wr_reg(VEC[k].addr, VEC[k].arg);
                OP_EV: pulse(VEC[k].arg[4:0]);
                default: rd_chk(VEC[k].addr, VEC[k].exp,
                                $sformatf("R%0d vector %0d", VEC[k].req, k));
            endcase
        end

        // R7: event and clearing read in the same cycle (reset-on-read on)
        wr_reg(4'd0, 32'h4);
        pulse(5'h09);
        pulse(5'h09);
        combo_chk(5'h09, 4'd1, 32'h2, "R7 miss read with event");
        combo_chk(5'h09, 4'd4, 32'h3, "R7 mgmt2 read with event");
        rd_chk(4'd1, 32'h2, "R7 miss kept event");
        rd_chk(4'd4, 32'h1, "R7 mgmt2 ends at one");
        wr_reg(4'd0, 32'h0);

        // R8: wide counter passes 8 bits, narrow one saturates
        ev_mgmt[3] = 1'b1; s_ev[0] = 1'b1;
        repeat (300) @(negedge clk);
        ev_mgmt[3] = 1'b0; s_ev[0] = 1'b0;
        rd_chk(4'd5, 32'd301, "R8 wide count");
        s_rd = 1'b1; s_addr = 4'd2;
        @(negedge clk);
        s_rd = 1'b0;
        check(s_rdata, 32'h0000_00FF, "R8 saturated at all ones");

        // R10: read data holds with no read strobe
        repeat (3) @(negedge clk);
        check(reg_rdata, 32'd301, "R10 rdata hold");

        // R3: wrap past 0xFFFF, flag stays through later events
        ev_miss = 1'b1;
        repeat (65539) @(negedge clk);
        ev_miss = 1'b0;
        wr_reg(4'd0, 32'h8);
        pulse(5'h01);
        rd_chk(4'd1, 32'h0001_0003, "R3 wrap with sticky flag");
        rd_chk(4'd1, 32'h0, "R2 read clears flag under freeze");

        // R11: reset clears state
        wr_reg(4'd0, 32'h0);
        pulse(5'h1F);
        wr_reg(4'd0, 32'hC);
        rd_chk(4'd5, 32'd302, "R11 pre-reset value");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(reg_rdata, 32'h0, "R11 rdata cleared");
        rd_chk(4'd0, 32'h0, "R11 control cleared");
        rd_chk(4'd1, 32'h0, "R11 miss cleared");
        rd_chk(4'd5, 32'h0, "R11 mgmt3 cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule